// File: doc/BRIEF.md
# Modem-Side Serial Link Handshake Controller

This block sits on the modem (DCE) side of a synchronous RS-232C style link. It works on logic-level signals only. It watches the terminal's ready and request-to-send leads and two local status inputs: power-on readiness and carrier. From these it drives data-set-ready, carrier-detect and clear-to-send back to the terminal. Ring and busy status are passed straight through to the terminal side.

Data moves only after a fixed ordering of the leads. First the terminal ready, local ready and carrier leads must all be asserted. Then the terminal raises its send request. After a fixed delay in clock cycles, the block answers with clear-to-send.

Two single-bit data lanes are gated by the handshake state. The transmit lane carries terminal data towards the remote modem. The receive lane carries remote data towards the terminal. Each lane captures its input only on a clock-enable strobe that marks the middle of a bit, so the sampled level is stable. A gated-off lane rests at mark (logic 1). The current handshake state is reported on a two-bit status output.

Top module: `dce_handshake_ctrl`

## Requirements
- R1: While reset is asserted, and after its release, `hs_state_o` reads 0 (IDLE), `clear_send_o` is 0, and both `line_data_o` and `term_data_o` rest at mark (1).
- R2: `set_ready_o`, `carrier_o`, `ring_o` and `busy_o` follow `local_ready_i`, `carrier_i`, `ring_i` and `busy_i` in the same cycle, with no register between them.
- R3: In IDLE, if `term_ready_i`, `local_ready_i` and `carrier_i` are all high at a clock edge, the state becomes 1 (READY) at that edge.
- R4: A send request held high in IDLE does not skip READY. The state becomes 2 (REQUESTED) only at an edge where `send_req_i` is high while the state is READY.
- R5: With `send_req_i` and the three readiness leads held high, the state becomes 3 (TRANSFER) exactly CTS_DELAY edges after REQUESTED is entered. `clear_send_o` is high exactly while the state is TRANSFER. The default CTS_DELAY is 4.
- R6: When `send_req_i` is low at an edge in REQUESTED or TRANSFER, with the readiness leads still high, the state returns to READY at that edge, so `clear_send_o` is low from that edge on.
- R7: If any of `term_ready_i`, `local_ready_i` or `carrier_i` is low at an edge, the state becomes IDLE at that edge. A drop during TRANSFER therefore removes `clear_send_o` within one clock.
- R8: While `clear_send_o` is high, `line_data_o` takes the value of `term_data_i` present at each edge where `tx_clk_en_i` is high, and holds it between strobes. While `clear_send_o` is low, `line_data_o` is mark (1) and strobes are ignored. The lane restarts from mark when TRANSFER is next entered.
- R9: While the state is not IDLE, `term_data_o` takes the value of `line_data_i` present at each edge where `rx_clk_en_i` is high, and holds it between strobes. In IDLE it is mark (1) and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| term_ready_i | input | 1 | Terminal powered and ready (DTR) |
| send_req_i | input | 1 | Terminal request to send (RTS) |
| local_ready_i | input | 1 | Local modem powered and ready |
| carrier_i | input | 1 | Local modem connected to the remote modem |
| ring_i | input | 1 | Ring status from the modem |
| busy_i | input | 1 | Busy status from the modem |
| tx_clk_en_i | input | 1 | Mid-bit strobe of the transmit clock |
| rx_clk_en_i | input | 1 | Mid-bit strobe of the receive clock |
| term_data_i | input | 1 | Serial data from the terminal |
| line_data_i | input | 1 | Serial data from the remote side |
| set_ready_o | output | 1 | Data-set-ready to the terminal (DSR) |
| carrier_o | output | 1 | Carrier-detect to the terminal (DCD) |
| clear_send_o | output | 1 | Clear-to-send to the terminal (CTS) |
| ring_o | output | 1 | Ring indicate to the terminal |
| busy_o | output | 1 | Busy indicate to the terminal |
| line_data_o | output | 1 | Gated transmit data towards the remote side |
| term_data_o | output | 1 | Gated receive data towards the terminal |
| hs_state_o | output | 2 | Handshake state: 0 IDLE, 1 READY, 2 REQUESTED, 3 TRANSFER |

## Verification
The bench builds the block with CTS_DELAY set to 3 rather than the default 4. At that value each request reaches TRANSFER in a handful of cycles, and the delay counter must stop at a value that is not one below a power of two. A random run with sticky readiness leads and a frequently toggled send request therefore reaches many grants, withdrawals and lead drops in each of the four states. Directed sequences pin down the exact grant edge, a send request raised before readiness, and strobes arriving while a lane is gated off.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_READY = 2'd1,
    HS_REQ   = 2'd2,
    HS_XFER  = 2'd3
  } hs_state_e;

  localparam logic LINE_MARK = 1'b1;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned TX_LANE   = 0;
  localparam int unsigned RX_LANE   = 1;

endpackage

// File: rtl/hs_seq.sv
module hs_seq
  import hs_pkg::*;
#(
  parameter int unsigned CTS_DELAY = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_up_i,
  input  logic      rts_i,
  output hs_state_e state_o,
  output logic      cts_o
);

  localparam int unsigned CW = (CTS_DELAY > 1) ? $clog2(CTS_DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(CTS_DELAY - 1);

  hs_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    if (!link_up_i) begin
      state_d = HS_IDLE;
    end else begin
      case (state_q)
        HS_IDLE:  state_d = HS_READY;
        HS_READY: if (rts_i) state_d = HS_REQ;
        HS_REQ: begin
          if (!rts_i)             state_d = HS_READY;
          else if (cnt_q == LAST) state_d = HS_XFER;
          else                    cnt_d   = cnt_q + CW'(1);
        end
        HS_XFER:  if (!rts_i) state_d = HS_READY;
        default:  state_d = HS_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cts_o   = (state_q == HS_XFER);

  // R5
  cts_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_o) |-> ($past(state_q) == HS_REQ) && ($past(cnt_q) == LAST));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_IDLE) |=> (state_q == HS_IDLE || state_q == HS_READY));

  // R6
  rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_i && !rts_i && (state_q == HS_REQ || state_q == HS_XFER))
      |=> (state_q == HS_READY));

endmodule

// File: rtl/hs_lane.sv
module hs_lane
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic stb_i,
  input  logic d_i,
  output logic q_o
);

  logic bit_q, bit_d;

  always_comb begin
    bit_d = bit_q;
    if (!gate_i)    bit_d = LINE_MARK;
    else if (stb_i) bit_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= LINE_MARK;
    else        bit_q <= bit_d;
  end

  assign q_o = gate_i ? bit_q : LINE_MARK;

  // R8, R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && !stb_i) |=> $stable(bit_q));

  // R8, R9
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && stb_i) |=> (bit_q == $past(d_i)));

endmodule

// File: rtl/dce_handshake_ctrl.sv
module dce_handshake_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned CTS_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       term_ready_i,
  input  logic       send_req_i,
  input  logic       local_ready_i,
  input  logic       carrier_i,
  input  logic       ring_i,
  input  logic       busy_i,
  input  logic       tx_clk_en_i,
  input  logic       rx_clk_en_i,
  input  logic       term_data_i,
  input  logic       line_data_i,
  output logic       set_ready_o,
  output logic       carrier_o,
  output logic       clear_send_o,
  output logic       ring_o,
  output logic       busy_o,
  output logic       line_data_o,
  output logic       term_data_o,
  output logic [1:0] hs_state_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // status pass-through
  assign set_ready_o = local_ready_i;
  assign carrier_o   = carrier_i;
  assign ring_o      = ring_i;
  assign busy_o      = busy_i;

  logic      link_up;
  hs_state_e state;
  logic      cts;

  assign link_up = term_ready_i & local_ready_i & carrier_i;

  hs_seq #(.CTS_DELAY(CTS_DELAY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .link_up_i (link_up),
    .rts_i     (send_req_i),
    .state_o   (state),
    .cts_o     (cts)
  );

  // gated data lanes
  logic [NUM_LANES-1:0] lane_gate, lane_stb, lane_d, lane_q;

  assign lane_gate[TX_LANE] = cts;
  assign lane_stb[TX_LANE]  = tx_clk_en_i;
  assign lane_d[TX_LANE]    = term_data_i;
  assign lane_gate[RX_LANE] = (state != HS_IDLE);
  assign lane_stb[RX_LANE]  = rx_clk_en_i;
  assign lane_d[RX_LANE]    = line_data_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    hs_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .gate_i (lane_gate[g]),
      .stb_i  (lane_stb[g]),
      .d_i    (lane_d[g]),
      .q_o    (lane_q[g])
    );
  end

  assign clear_send_o = cts;
  assign line_data_o  = lane_q[TX_LANE];
  assign term_data_o  = lane_q[RX_LANE];
  assign hs_state_o   = state;

  // R7
  link_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clear_send_o && !link_up) |=> !clear_send_o);

  // R8
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clear_send_o && !cts) |=> (!clear_send_o || line_data_o == LINE_MARK));

endmodule

// File: tb/tb_dce_handshake_ctrl.sv
module tb_dce_handshake_ctrl;

  localparam int D = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, dtr, rts, pwr, car, rng, bsy, tc, rc, td, rx;
  logic dsr_o, dcd_o, cts_o, ri_o, busy_o, ltx_o, rd_o;
  logic [1:0] st_o;

  dce_handshake_ctrl #(.CTS_DELAY(D)) dut (
    .clk(clk), .rst_n(rst_n), .term_ready_i(dtr), .send_req_i(rts),
    .local_ready_i(pwr), .carrier_i(car), .ring_i(rng), .busy_i(bsy),
    .tx_clk_en_i(tc), .rx_clk_en_i(rc), .term_data_i(td), .line_data_i(rx),
    .set_ready_o(dsr_o), .carrier_o(dcd_o), .clear_send_o(cts_o),
    .ring_o(ri_o), .busy_o(busy_o), .line_data_o(ltx_o),
    .term_data_o(rd_o), .hs_state_o(st_o)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  // reference model
  logic [1:0] m_st;
  int         m_cnt;
  logic       m_tx, m_rx;
  string      m_why;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 2'd0; m_cnt = 0; m_tx = 1'b1; m_rx = 1'b1; m_why = "R1";
  endtask

  task automatic model_step();
    logic link;
    logic [1:0] st;
    st   = m_st;
    link = dtr & pwr & car;
    m_tx = (st == 2'd3) ? (tc ? td : m_tx) : 1'b1;
    m_rx = (st != 2'd0) ? (rc ? rx : m_rx) : 1'b1;
    m_cnt = 0;
    if (!link) begin
      m_st = 2'd0; m_why = (st != 2'd0) ? "R7" : "R3";
    end else begin
      case (st)
        2'd0: begin m_st = 2'd1; m_why = "R3"; end
        2'd1: begin m_st = rts ? 2'd2 : 2'd1; m_why = "R4"; end
        default: begin
          if (!rts) begin m_st = 2'd1; m_why = "R6"; end
          else if (st == 2'd2) begin
            m_why = "R5";
            if (m_cnt_prev == D - 1) m_st = 2'd3;
            else m_cnt = m_cnt_prev + 1;
          end else m_why = "R5";
        end
      endcase
    end
    m_cnt_prev = m_cnt;
  endtask

  int m_cnt_prev = 0;

  task automatic compare();
    chk("R2", {4'd0, dsr_o, dcd_o, ri_o, busy_o}, {4'd0, pwr, car, rng, bsy});
    chk(m_why, {6'd0, st_o}, {6'd0, m_st});
    chk("R5", {7'd0, cts_o}, {7'd0, (m_st == 2'd3)});
    chk("R8", {7'd0, ltx_o}, {7'd0, (m_st == 2'd3) ? m_tx : 1'b1});
    chk("R9", {7'd0, rd_o}, {7'd0, (m_st != 2'd0) ? m_rx : 1'b1});
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst_n) begin model_reset(); m_cnt_prev = 0; end
    else model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    {dtr, rts, pwr, car, rng, bsy, tc, rc, td, rx} = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {6'd0, st_o}, 8'd0);
    chk("R1", {7'd0, cts_o}, 8'd0);
    chk("R1", {7'd0, ltx_o}, 8'd1);
    chk("R1", {7'd0, rd_o}, 8'd1);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1", {6'd0, st_o}, 8'd0);

    // R2 pass-through in the same cycle
    rng = 1'b1; bsy = 1'b1; pwr = 1'b1;
    #1;
    chk("R2", {5'd0, dsr_o, ri_o, busy_o}, 8'd7);

    // R4: send request raised before the leads
    rts = 1'b1; cyc();
    chk("R4", {6'd0, st_o}, 8'd0);
    dtr = 1'b1; car = 1'b1; cyc();
    chk("R4", {6'd0, st_o}, 8'd1);
    cyc();
    chk("R4", {6'd0, st_o}, 8'd2);
    // R5 exact grant edge
    for (int k = 1; k <= D; k++) begin
      cyc();
      chk("R5", {7'd0, cts_o}, {7'd0, k == D});
    end

    // R8 capture and hold
    tc = 1'b1; td = 1'b0; cyc();
    chk("R8", {7'd0, ltx_o}, 8'd0);
    tc = 1'b0; td = 1'b1; cyc();
    chk("R8", {7'd0, ltx_o}, 8'd0);
    tc = 1'b1; cyc();
    chk("R8", {7'd0, ltx_o}, 8'd1);

    // R6 request withdrawn
    rts = 1'b0; tc = 1'b0; cyc();
    chk("R6", {6'd0, st_o}, 8'd1);
    chk("R6", {7'd0, cts_o}, 8'd0);
    // R8 strobe ignored while gated off
    tc = 1'b1; td = 1'b0; cyc();
    chk("R8", {7'd0, ltx_o}, 8'd1);
    // R9 receive lane active in READY
    rc = 1'b1; rx = 1'b0; cyc();
    chk("R9", {7'd0, rd_o}, 8'd0);
    rc = 1'b0; tc = 1'b0;

    // R7 carrier drop during transfer
    rts = 1'b1;
    repeat (D + 1) cyc();
    chk("R5", {7'd0, cts_o}, 8'd1);
    car = 1'b0; #1;
    chk("R2", {7'd0, dcd_o}, 8'd0);
    cyc();
    chk("R7", {7'd0, cts_o}, 8'd0);
    chk("R7", {6'd0, st_o}, 8'd0);
    rc = 1'b1; rx = 1'b0; cyc();
    chk("R9", {7'd0, rd_o}, 8'd1);
    rc = 1'b0;
    // R3 leads back up
    car = 1'b1; cyc();
    chk("R3", {6'd0, st_o}, 8'd1);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if (dtr) dtr = ($urandom_range(0, 79) != 0); else dtr = ($urandom_range(0, 3) == 0);
      if (pwr) pwr = ($urandom_range(0, 99) != 0); else pwr = ($urandom_range(0, 3) == 0);
      if (car) car = ($urandom_range(0, 79) != 0); else car = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 11) == 0) rts = ~rts;
      rng = $urandom_range(0, 1);
      bsy = $urandom_range(0, 1);
      tc  = ($urandom_range(0, 3) == 0);
      rc  = ($urandom_range(0, 3) == 0);
      td  = $urandom_range(0, 1);
      rx  = $urandom_range(0, 1);
      cyc();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule